// File: doc/BRIEF.md
# Presettable 8-bit Base Timer with Sticky Interrupt

This block is a free-running 8-bit up-counter for a small microcontroller subsystem. A prescaler divides the 4 MHz system clock by four, so the count moves once per microsecond. Software controls the block through three write-only registers on a simple write port, made up of an address, a data byte and a write strobe. One register loads the count. One starts or stops the timer. One clears the interrupt.

The count always wraps from all-ones back to zero. The edge on which it becomes all-ones sets a sticky flag. Software cannot read this flag. It stays set until a clear write with bit 0 high. The `irq` line is the flag qualified by the `irq_en` input. The count value is also driven out so that neighbouring logic can observe it.

Run control is a two-state machine:
- ST_STOP is entered at reset and through transition T_HALT, a control write with bit 0 = 1.
- ST_RUN is entered through transition T_START, a control write with bit 0 = 0.
- Every other cycle holds the current state.

Top module: `btmr_top`

## Requirements
- R1: After reset the count is 0x00, the timer is in ST_STOP, the flag is clear and `irq` is low.
- R2: In ST_RUN the count advances by one every 4 clock cycles. After the edge that starts the timer, the first advance happens on the 4th rising edge.
- R3: A write to address 0x00C0 loads the count with the data byte on that edge, whether the timer runs or not. It also restarts the prescaler phase, so the next advance comes 4 edges later.
- R4: A write to address 0x00C1 looks only at bit 0. A 0 moves the timer to ST_RUN and a 1 moves it to ST_STOP. In ST_STOP the count holds, and the other data bits have no effect.
- R5: The flag sets on the edge where the count advances from 0xFE to 0xFF. Loading 0xFF directly through the preset register does not set it.
- R6: After 0xFF the next advance gives 0x00 and counting continues. The preset value is not reloaded.
- R7: The flag is sticky. A write to 0x00C2 with bit 0 = 1 clears it on that edge, and a write to 0x00C2 with bit 0 = 0 has no effect.
- R8: If the flag-setting advance and a clear write fall on the same edge, the flag ends up set.
- R9: `irq` is high exactly when the flag is set and `irq_en` is high. Holding `irq_en` low does not lose the flag.
- R10: Writes to any address other than the three above, including addresses that differ only in upper bits, change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 4 MHz system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one write per high cycle |
| wr_addr | input | 16 | Write address |
| wr_data | input | 8 | Write data byte |
| irq_en | input | 1 | Interrupt enable, qualifies `irq` |
| irq | output | 1 | Timer interrupt request, active high |
| cnt_val | output | 8 | Current count value |

## Verification
The hardest case to reach is a clear write that lands on exactly the edge where the count steps from 0xFE to 0xFF. Only then does the set-over-clear priority matter.

The stimulus gets there by presetting 0xFE while the timer runs, which also zeroes the prescaler phase. It then idles three cycles and issues the clear on the fourth. Random traffic with preset values biased toward the top of the range adds more near-collisions, and a cycle-level bench model compares every cycle.

// File: rtl/btmr_pkg.sv
package btmr_pkg;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } btmr_state_e;

    typedef struct packed {
        logic preset;
        logic ctrl;
        logic clr;
    } btmr_strb_s;

endpackage

// File: rtl/btmr_decode.sv
module btmr_decode
    import btmr_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8,
    parameter logic [ADDR_W-1:0] ADDR_PRESET = 16'h00C0,
    parameter logic [ADDR_W-1:0] ADDR_CTRL   = 16'h00C1,
    parameter logic [ADDR_W-1:0] ADDR_CLR    = 16'h00C2
) (
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output btmr_strb_s        strb,
    output logic              ctrl_bit
);

    always_comb begin
        strb.preset = wr_en && (wr_addr == ADDR_PRESET);
        strb.ctrl   = wr_en && (wr_addr == ADDR_CTRL);
        strb.clr    = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];
        ctrl_bit    = wr_data[0];
    end

endmodule

// File: rtl/btmr_ctrl.sv
module btmr_ctrl
    import btmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic ctrl_bit,
    output logic run
);

    btmr_state_e state_q;
    btmr_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions: T_START (bit 0 written low), T_HALT (bit 0 written high)
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOP: if (ctrl_wr && !ctrl_bit) state_d = ST_RUN;
            ST_RUN:  if (ctrl_wr &&  ctrl_bit) state_d = ST_STOP;
            default: state_d = ST_STOP;
        endcase
    end

    // Outputs
    always_comb begin
        run = (state_q == ST_RUN);
    end

endmodule

// File: rtl/btmr_prescale.sv
module btmr_prescale #(
    parameter int DIV = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic restart,
    output logic tick
);

    generate
        if (DIV <= 1) begin : g_pass
            assign tick = run && !restart;
        end else begin : g_div
            localparam int PRE_W = $clog2(DIV);
            localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(DIV - 1);

            logic [PRE_W-1:0] phase_q;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    phase_q <= '0;
                end else if (!run || restart || (phase_q == PRE_LAST)) begin
                    phase_q <= '0;
                end else begin
                    phase_q <= phase_q + PRE_W'(1);
                end
            end

            assign tick = run && !restart && (phase_q == PRE_LAST);
        end
    endgenerate

endmodule

// File: rtl/btmr_irq.sv
module btmr_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_wr,
    input  logic irq_en,
    output logic flag,
    output logic irq
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set_evt) begin
            flag <= 1'b1;
        end else if (clr_wr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag && irq_en;

endmodule

// File: rtl/btmr_top.sv
module btmr_top
    import btmr_pkg::*;
#(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter int DIV    = 4,
    parameter logic [ADDR_W-1:0] ADDR_PRESET = 16'h00C0,
    parameter logic [ADDR_W-1:0] ADDR_CTRL   = 16'h00C1,
    parameter logic [ADDR_W-1:0] ADDR_CLR    = 16'h00C2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [CNT_W-1:0]  wr_data,
    input  logic              irq_en,
    output logic              irq,
    output logic [CNT_W-1:0]  cnt_val
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_PRE = CNT_MAX - CNT_W'(1);

    btmr_strb_s       strb;
    logic             ctrl_bit;
    logic             run;
    logic             tick;
    logic             set_evt;
    logic             flag;
    logic [CNT_W-1:0] cnt_q;

    btmr_decode #(
        .ADDR_W     (ADDR_W),
        .DATA_W     (CNT_W),
        .ADDR_PRESET(ADDR_PRESET),
        .ADDR_CTRL  (ADDR_CTRL),
        .ADDR_CLR   (ADDR_CLR)
    ) u_decode (
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .strb    (strb),
        .ctrl_bit(ctrl_bit)
    );

    btmr_ctrl u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctrl_wr (strb.ctrl),
        .ctrl_bit(ctrl_bit),
        .run     (run)
    );

    btmr_prescale #(
        .DIV(DIV)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (run),
        .restart(strb.preset),
        .tick   (tick)
    );

    // Count register: preset wins over an advance on the same edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (strb.preset) begin
            cnt_q <= wr_data;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign set_evt = tick && (cnt_q == CNT_PRE);
    assign cnt_val = cnt_q;

    btmr_irq u_irq (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(set_evt),
        .clr_wr (strb.clr),
        .irq_en (irq_en),
        .flag   (flag),
        .irq    (irq)
    );

endmodule

// File: rtl/btmr_chk.sv
module btmr_chk #(
    parameter int CNT_W  = 8,
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] ADDR_PRESET = 16'h00C0,
    parameter logic [ADDR_W-1:0] ADDR_CTRL   = 16'h00C1,
    parameter logic [ADDR_W-1:0] ADDR_CLR    = 16'h00C2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [CNT_W-1:0]  wr_data,
    input logic              irq_en,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt_val,
    input logic              flag
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] TOP_M1 = TOP - CNT_W'(1);

    logic pre_wr;
    logic halt_wr;
    logic clr_wr;

    assign pre_wr  = wr_en && (wr_addr == ADDR_PRESET);
    assign halt_wr = wr_en && (wr_addr == ADDR_CTRL) && wr_data[0];
    assign clr_wr  = wr_en && (wr_addr == ADDR_CLR) && wr_data[0];

    assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(pre_wr) && (cnt_val != $past(cnt_val)))
            |-> (cnt_val == $past(cnt_val) + CNT_W'(1)));

    assert_preset_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pre_wr |=> (cnt_val == $past(wr_data)));

    assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (halt_wr && !pre_wr) ##1 !pre_wr |=> $stable(cnt_val));

    assert_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag) |-> ((cnt_val == TOP) && ($past(cnt_val) == TOP_M1)));

    assert_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(cnt_val) == TOP) && (cnt_val != TOP) && !$past(pre_wr))
            |-> (cnt_val == '0));

    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr_wr) |=> flag);

    assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_wr && (cnt_val != TOP_M1)) |=> !flag);

    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((cnt_val == TOP) && ($past(cnt_val) == TOP_M1) && !$past(pre_wr)) |-> flag);

    assert_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_en || !flag) |-> !irq);

endmodule

bind btmr_top btmr_chk #(
    .CNT_W      (CNT_W),
    .ADDR_W     (ADDR_W),
    .ADDR_PRESET(ADDR_PRESET),
    .ADDR_CTRL  (ADDR_CTRL),
    .ADDR_CLR   (ADDR_CLR)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_addr(wr_addr),
    .wr_data(wr_data),
    .irq_en (irq_en),
    .irq    (irq),
    .cnt_val(cnt_val),
    .flag   (flag)
);

// File: tb/btmr_top_tb_top.sv
`timescale 1ns/1ps
module btmr_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [15:0] wr_addr = 16'h0000;
    logic [7:0]  wr_data = 8'h00;
    logic        irq_en = 1'b1;
    logic        irq;
    logic [7:0]  cnt_val;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Bench model state
    bit       m_run;
    int       m_pre;
    bit [7:0] m_cnt;
    bit       m_flag;

    always #4 clk = ~clk;

    btmr_top dut_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .irq_en (irq_en),
        .irq    (irq),
        .cnt_val(cnt_val)
    );

    function automatic bit [7:0] f_next_cnt(bit pre_w, bit [7:0] d, bit tk, bit [7:0] c);
        if (pre_w) return d;
        if (tk) return c + 8'd1;
        return c;
    endfunction

    function automatic bit f_next_flag(bit set_e, bit clr_e, bit f);
        if (set_e) return 1'b1;
        if (clr_e) return 1'b0;
        return f;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_run = 0; m_pre = 0; m_cnt = 0; m_flag = 0;
        end else begin
            bit pre_w, ctl_w, clr_w, tk, set_e;
            pre_w = wr_en && (wr_addr == 16'h00C0);
            ctl_w = wr_en && (wr_addr == 16'h00C1);
            clr_w = wr_en && (wr_addr == 16'h00C2) && wr_data[0];
            tk    = m_run && !pre_w && (m_pre == 3);
            set_e = tk && (m_cnt == 8'hFE);
            m_flag = f_next_flag(set_e, clr_w, m_flag);
            m_cnt  = f_next_cnt(pre_w, wr_data, tk, m_cnt);
            m_pre  = (!m_run || pre_w) ? 0 : (m_pre + 1) % 4;
            if (ctl_w) m_run = !wr_data[0];
        end
    end

    task automatic chk_val(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic compare(input string tag);
        chk_val({tag, " count"}, int'(cnt_val), int'(m_cnt));
        chk_val({tag, " irq"}, int'(irq), int'(m_flag && irq_en));
    endtask

    task automatic step(input bit we, input bit [15:0] a, input bit [7:0] d, input string tag);
        @(negedge clk);
        compare(tag);
        wr_en = we; wr_addr = a; wr_data = d;
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 8'h00, tag);
    endtask

    task automatic summary;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        #(8ns * 150000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL R1 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240607));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk_val("R1 reset count", int'(cnt_val), 0);
        chk_val("R1 reset irq", int'(irq), 0);
        idle(6, "R1 stopped");
        chk_val("R1 held while stopped", int'(cnt_val), 0);

        // R2: start, first advance on 4th edge
        step(1'b1, 16'h00C1, 8'h00, "R2");
        idle(4, "R2");
        @(negedge clk);
        chk_val("R2 first advance", int'(cnt_val), 1);
        idle(20, "R2");

        // R3: preset while running and stopped
        step(1'b1, 16'h00C0, 8'h40, "R3");
        idle(9, "R3");
        step(1'b1, 16'h00C1, 8'h01, "R3");
        step(1'b1, 16'h00C0, 8'h99, "R3");
        idle(6, "R3");
        chk_val("R3 preset stopped", int'(cnt_val), 8'h99);

        // R4: other control bits ignored
        step(1'b1, 16'h00C1, 8'hFE, "R4");
        idle(9, "R4");
        step(1'b1, 16'h00C1, 8'hA1, "R4");
        idle(9, "R4");
        step(1'b1, 16'h00C1, 8'h00, "R4");

        // R5: direct preset to FF does not set the flag
        step(1'b1, 16'h00C0, 8'hFF, "R5");
        idle(3, "R5");
        chk_val("R5 preset FF no flag", int'(irq), 0);
        // R5/R6: count through FE->FF then wrap
        step(1'b1, 16'h00C0, 8'hFC, "R5");
        idle(16, "R5");
        chk_val("R5 flag set", int'(irq), 1);
        idle(8, "R6");
        chk_val("R6 wrapped", int'(cnt_val), 8'h01);

        // R7: clear with bit 0 low has no effect, then real clear
        step(1'b1, 16'h00C2, 8'hFE, "R7");
        idle(1, "R7");
        chk_val("R7 no-op clear", int'(irq), 1);
        step(1'b1, 16'h00C2, 8'h01, "R7");
        idle(1, "R7");
        chk_val("R7 cleared", int'(irq), 0);

        // R8: clear on the same edge as FE->FF
        step(1'b1, 16'h00C0, 8'hFE, "R8");
        idle(3, "R8");
        step(1'b1, 16'h00C2, 8'h01, "R8");
        idle(1, "R8");
        chk_val("R8 set wins", int'(irq), 1);

        // R9: gating keeps the flag
        irq_en = 1'b0;
        idle(3, "R9");
        chk_val("R9 gated low", int'(irq), 0);
        irq_en = 1'b1;
        idle(1, "R9");
        chk_val("R9 flag kept", int'(irq), 1);
        step(1'b1, 16'h00C2, 8'h01, "R9");

        // R10: foreign addresses ignored
        step(1'b1, 16'h00C1, 8'h01, "R10");
        step(1'b1, 16'h00C0, 8'h33, "R10");
        step(1'b1, 16'h01C0, 8'h77, "R10");
        step(1'b1, 16'h00C3, 8'h00, "R10");
        step(1'b1, 16'h10C1, 8'h00, "R10");
        idle(6, "R10");
        chk_val("R10 ignored", int'(cnt_val), 8'h33);

        // Random traffic against the bench model
        for (int i = 0; i < 4000; i++) begin
            int r;
            bit [7:0] d;
            r = $urandom_range(0, 99);
            d = 8'($urandom);
            if ($urandom_range(0, 49) == 0) irq_en = ~irq_en;
            if (r < 6) begin
                if ($urandom_range(0, 1) == 1) d = 8'hF0 | (d & 8'h0F);
                step(1'b1, 16'h00C0, d, "R2 random");
            end else if (r < 11) begin
                if ($urandom_range(0, 3) != 0) d[0] = 1'b0;
                step(1'b1, 16'h00C1, d, "R2 random");
            end else if (r < 16) begin
                step(1'b1, 16'h00C2, d, "R2 random");
            end else if (r < 19) begin
                step(1'b1, 16'($urandom) | 16'h0100, d, "R2 random");
            end else begin
                idle(1, "R2 random");
            end
        end
        idle(2, "R2 random");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule